// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block is a single-channel DMA engine that moves a block of words between one peripheral and memory, one word per borrowed bus cycle. The host programs it through a small register port: the direction, the peripheral number, the first memory address and the number of words. A start bit then launches the transfer.

For each word the engine waits until the peripheral reports that it is ready. It then requests the system bus and waits for the grant. It performs exactly one memory access and hands the bus back in the following cycle, so the processor only stalls around its own next bus access and loses no state. After each word the address register steps up by one and the count register steps down by one. When the count reaches zero the engine sets a done flag, which also drives the interrupt output. The host clears the flag by writing the status register.

Top module: `dma_steal`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low, `bus_req_o` is low and `mem_req_o` is low.
- R2: The host register offsets are as follows.
  - 0: control. Bit 0 is start and writes as a pulse. Bit 1 is the direction: 0 moves words from the device to memory, 1 moves them from memory to the device.
  - 1: peripheral number.
  - 2: memory address.
  - 3: word count.
  - 4: status. Bit 0 is busy and bit 1 is done.
  - Reads are combinational. The start bit reads as 0.
- R3: `bus_req_o` rises only in the cycle after `dev_rdy_i` was sampled high by a busy engine. `mem_req_o` is high only while `bus_grant_i` and `bus_req_o` are both high.
- R4: Each bus ownership carries exactly one memory access. `bus_req_o` is low in the cycle after the memory handshake (`mem_req_o` and `mem_ack_i`).
- R5: Each completed word increments the address register and decrements the count register. After a block of N words, the address register reads start+N and the count register reads 0.
- R6: With direction 0, each memory access is a write (`mem_we_o` high) of `dev_rdata_i`, and the words land at consecutive addresses in arrival order.
- R7: With direction 1, each memory access is a read, and `dev_wdata_o` carries the word read from memory in the cycle in which `dev_ack_o` pulses, in address order.
- R8: Done and `irq_o` rise on the clock edge that completes the last word, and busy clears on the same edge. The interrupt is never raised before every word has moved.
- R9: A start with a count of zero sets done and `irq_o` on the start-write edge and issues no bus request.
- R10: Any write to the status register clears done and `irq_o`.
- R11: While busy, host writes to the control, peripheral, address and count registers have no effect, and a further start is ignored.
- R12: `dev_id_o` presents the programmed peripheral number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register offset |
| reg_wdata_i | input | AW (16) | Host write data |
| reg_rdata_o | output | AW (16) | Host read data |
| irq_o | output | 1 | Block-complete interrupt |
| bus_req_o | output | 1 | Bus request to the host |
| bus_grant_i | input | 1 | Bus grant from the host |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW (16) | Memory address |
| mem_wdata_o | output | DW (8) | Memory write data |
| mem_rdata_i | input | DW (8) | Memory read data |
| mem_ack_i | input | 1 | Memory access complete |
| dev_id_o | output | IDW (4) | Selected peripheral number |
| dev_rdy_i | input | 1 | Peripheral has data (direction 0) or space (direction 1) |
| dev_rdata_i | input | DW (8) | Word from the peripheral |
| dev_wdata_o | output | DW (8) | Word to the peripheral |
| dev_ack_o | output | 1 | Word taken from or given to the peripheral |

## Verification
Register reads are due in the same cycle as the offset, and a start takes effect at the write edge. `bus_req_o` follows one edge after a sampled `dev_rdy_i`, and the memory handshake falls in the cycle in which the grant is seen. Done and `irq_o` land on the edge of the final handshake, or on the start edge for a zero count. The bench changes inputs and samples outputs only on falling edges, so every value it checks has settled after the rising edge that produced it. A monitor sampling on rising edges counts ownerships, accesses, grant violations and the cycle after each handshake in which `bus_req_o` must already be low.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_DEV   = 3'd1;
  localparam logic [2:0] REG_ADDR  = 3'd2;
  localparam logic [2:0] REG_COUNT = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUS  = 2'd2
  } dma_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_steal_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int IDW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [2:0]     addr_i,
  input  logic [AW-1:0]  wdata_i,
  output logic [AW-1:0]  rdata_o,
  input  logic           busy_i,
  input  logic           step_i,
  input  logic           done_set_i,
  output logic           start_o,
  output logic           dir_o,
  output logic [IDW-1:0] dev_id_o,
  output logic [AW-1:0]  addr_o,
  output logic [CW-1:0]  count_o,
  output logic           done_o
);
  logic cfg_wr;
  assign cfg_wr  = wr_en_i && !busy_i;
  assign start_o = cfg_wr && (addr_i == REG_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o    <= 1'b0;
      dev_id_o <= '0;
      addr_o   <= '0;
      count_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      if (cfg_wr && addr_i == REG_CTRL)  dir_o    <= wdata_i[1];
      if (cfg_wr && addr_i == REG_DEV)   dev_id_o <= wdata_i[IDW-1:0];
      if (cfg_wr && addr_i == REG_ADDR)  addr_o   <= wdata_i;
      else if (step_i)                   addr_o   <= addr_o + AW'(1);
      if (cfg_wr && addr_i == REG_COUNT) count_o  <= wdata_i[CW-1:0];
      else if (step_i)                   count_o  <= count_o - CW'(1);
      // set beats clear so a zero-count start still reports done
      if (done_set_i)                                done_o <= 1'b1;
      else if (start_o)                              done_o <= 1'b0;
      else if (wr_en_i && addr_i == REG_STAT)        done_o <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL:  rdata_o = AW'({dir_o, 1'b0});
      REG_DEV:   rdata_o = AW'(dev_id_o);
      REG_ADDR:  rdata_o = addr_o;
      REG_COUNT: rdata_o = AW'(count_o);
      REG_STAT:  rdata_o = AW'({done_o, busy_i});
      default:   rdata_o = '0;
    endcase
  end

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> addr_o == $past(addr_o) + AW'(1)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> count_o == $past(count_o) - CW'(1)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> count_o != '0); // R5
  AST_ZERO_START_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && count_o == '0) |=> done_o); // R9
  AST_BUSY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !step_i) |=> $stable(addr_o) && $stable(count_o)); // R11
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_steal_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          dev_rdy_i,
  input  logic          bus_grant_i,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          bus_req_o,
  output logic          mem_req_o,
  output logic          step_o,
  output logic          done_set_o
);
  dma_state_e state_q, state_d;
  logic last_word;

  assign busy_o     = state_q != ST_IDLE;
  assign bus_req_o  = state_q == ST_BUS;
  assign mem_req_o  = bus_req_o && bus_grant_i;
  assign step_o     = mem_req_o && mem_ack_i;
  assign last_word  = count_i == CW'(1);
  assign done_set_o = (state_q == ST_IDLE && start_i && count_i == '0) ||
                      (step_o && last_word);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i && count_i != '0) state_d = ST_WAIT;
      ST_WAIT: if (dev_rdy_i) state_d = ST_BUS;
      ST_BUS:  if (step_o) state_d = last_word ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_GRANTED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> bus_grant_i && bus_req_o); // R3
  AST_REQ_AFTER_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(dev_rdy_i) && $past(busy_o)); // R3
  AST_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !bus_req_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o && !mem_req_o); // R9
  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last_word) |=> !busy_o); // R8
endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_steal_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CW  = 8,
  parameter int IDW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [AW-1:0]  reg_wdata_i,
  output logic [AW-1:0]  reg_rdata_o,
  output logic           irq_o,
  output logic           bus_req_o,
  input  logic           bus_grant_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ack_i,
  output logic [IDW-1:0] dev_id_o,
  input  logic           dev_rdy_i,
  input  logic [DW-1:0]  dev_rdata_i,
  output logic [DW-1:0]  dev_wdata_o,
  output logic           dev_ack_o
);
  logic          busy, step, done_set, start, dir, done;
  logic [CW-1:0] count;

  dma_regs #(.AW(AW), .CW(CW), .IDW(IDW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .step_i     (step),
    .done_set_i (done_set),
    .start_o    (start),
    .dir_o      (dir),
    .dev_id_o   (dev_id_o),
    .addr_o     (mem_addr_o),
    .count_o    (count),
    .done_o     (done)
  );

  dma_engine #(.CW(CW)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .count_i     (count),
    .dev_rdy_i   (dev_rdy_i),
    .bus_grant_i (bus_grant_i),
    .mem_ack_i   (mem_ack_i),
    .busy_o      (busy),
    .bus_req_o   (bus_req_o),
    .mem_req_o   (mem_req_o),
    .step_o      (step),
    .done_set_o  (done_set)
  );

  // dir 0: device -> memory (write), dir 1: memory -> device (read)
  assign mem_we_o    = mem_req_o && !dir;
  assign mem_wdata_o = dev_rdata_i;
  assign dev_wdata_o = mem_rdata_i;
  assign dev_ack_o   = step;
  assign irq_o       = done;

  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_STAT && !done_set) |=> !irq_o); // R10
endmodule

// File: tb/tb_dma_steal.sv
module tb_dma_steal;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 8, CW = 8, IDW = 4;

  logic           clk = 1'b0, rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [2:0]     reg_addr = 3'd0;
  logic [AW-1:0]  reg_wdata = '0, reg_rdata;
  logic           irq, bus_req, bus_grant, mem_req, mem_we, mem_ack, dev_rdy, dev_ack;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic [IDW-1:0] dev_id;

  int checks = 0, fails = 0;
  int words, owners, gap_err, nogrant, src_idx, sidx, cyc;
  int gdelay = 0, rperiod = 1, gcnt;
  logic prev_ack, prev_req;
  logic [7:0] mem  [0:255];
  logic [7:0] sink [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_steal #(.AW(AW), .DW(DW), .CW(CW), .IDW(IDW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .bus_req_o(bus_req), .bus_grant_i(bus_grant), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .dev_id_o(dev_id),
    .dev_rdy_i(dev_rdy), .dev_rdata_i(dev_rdata), .dev_wdata_o(dev_wdata),
    .dev_ack_o(dev_ack)
  );

  // memory, peripheral and host-arbiter models
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = 8'(src_idx * 37 + 5);
  assign dev_rdy   = (cyc % rperiod) == 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_grant <= 1'b0; gcnt <= 0; cyc <= 0; prev_ack <= 1'b0; prev_req <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (!bus_req) begin bus_grant <= 1'b0; gcnt <= 0; end
      else if (gcnt >= gdelay) bus_grant <= 1'b1;
      else gcnt <= gcnt + 1;
      if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_req) words <= words + 1;
      if (mem_req && !bus_grant) nogrant <= nogrant + 1;
      if (prev_ack && bus_req) gap_err <= gap_err + 1;
      if (bus_req && !prev_req) owners <= owners + 1;
      prev_ack <= mem_req && mem_ack;
      prev_req <= bus_req;
      if (dev_ack && !mem_we) begin sink[sidx[3:0]] <= dev_wdata; sidx <= sidx + 1; end
      if (dev_ack && mem_we) src_idx <= src_idx + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [AW-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    words = 0; owners = 0; gap_err = 0; nogrant = 0; src_idx = 0; sidx = 0;
  endtask

  task automatic run(input bit dir, input int n, input int gd, input int rp);
    logic [AW-1:0] start, v;
    bit bad;
    int id;
    start = AW'(16'h0020 + n * 16 + (dir ? 128 : 0));
    id = (n * 3 + gd + rp) % 16;
    gdelay = gd; rperiod = rp;
    for (int a = 0; a < 256; a++) mem[a] = dir ? 8'(a * 11 + 3) : 8'h00;
    clear_mon();
    reg_wr(3'd1, AW'(id));
    reg_wr(3'd2, start);
    reg_wr(3'd3, AW'(n));
    reg_wr(3'd0, AW'({dir, 1'b1}));
    if (n == 0) begin
      chk(irq == 1'b1, "R9 zero-count irq at start edge", irq, 1);
      repeat (4) @(negedge clk);
      chk(owners == 0, "R9 zero-count bus requests", owners, 0);
    end else begin
      for (int t = 0; t < 400 && !irq; t++) @(negedge clk);
      chk(words == n, "R8 words moved when irq seen", words, n);
      chk(bus_req == 1'b0, "R8 bus released at done", bus_req, 0);
      chk(owners == n, "R4 one ownership per word", owners, n);
      chk(gap_err == 0, "R4 req low after handshake", gap_err, 0);
      chk(nogrant == 0, "R3 memory access only with grant", nogrant, 0);
    end
    reg_rd(3'd2, v); chk(v == start + AW'(n), "R5 final address", v, start + AW'(n));
    reg_rd(3'd3, v); chk(v == 0, "R5 final count", v, 0);
    reg_rd(3'd4, v); chk(v == 16'h2, "R8 status done not busy", v, 2);
    reg_rd(3'd0, v); chk(v == AW'({dir, 1'b0}), "R2 control readback", v, {dir, 1'b0});
    reg_rd(3'd1, v); chk(v == AW'(id), "R2 peripheral readback", v, id);
    chk(dev_id == IDW'(id), "R12 dev_id_o", dev_id, id);
    bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!dir && mem[8'(start) + 8'(i)] != 8'(i * 37 + 5)) bad = 1'b1;
      if (dir && sink[i] != 8'((start + AW'(i)) * 11 + 3)) bad = 1'b1;
    end
    if (dir) chk(!bad && sidx == n, "R7 device received memory words", sidx, n);
    else     chk(!bad && src_idx == n, "R6 memory holds device words", src_idx, n);
    reg_wr(3'd4, '0);
    chk(irq == 1'b0, "R10 irq cleared by status write", irq, 0);
    reg_rd(3'd4, v); chk(v == 0, "R10 status after clear", v, 0);
  endtask

  initial begin
    logic [AW-1:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    ok = 1'b1;
    for (int a = 0; a < 5; a++) begin reg_rd(3'(a), v); if (v != 0) ok = 1'b0; end
    chk(ok, "R1 registers zero after reset", ok, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!irq && !bus_req && !mem_req, "R1 outputs idle after reset", {irq, bus_req, mem_req}, 0);

    for (int d = 0; d < 2; d++)
      for (int n = 0; n < 6; n++)
        for (int g = 0; g < 3; g++)
          for (int r = 1; r < 3; r++)
            run(d[0], n, g, r);

    // R11: config writes and restart while busy are ignored
    gdelay = 2; rperiod = 3;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    clear_mon();
    reg_wr(3'd1, 16'h5);
    reg_wr(3'd2, 16'h0010);
    reg_wr(3'd3, 16'd4);
    reg_wr(3'd0, 16'h1);
    reg_wr(3'd2, 16'h00F0);
    reg_wr(3'd3, 16'd9);
    reg_wr(3'd1, 16'hA);
    reg_wr(3'd0, 16'h3);
    for (int t = 0; t < 400 && !irq; t++) @(negedge clk);
    reg_rd(3'd2, v); chk(v == 16'h0014, "R11 address ignores busy write", v, 16'h14);
    reg_rd(3'd0, v); chk(v == 16'h0, "R11 direction ignores busy write", v, 0);
    reg_rd(3'd1, v); chk(v == 16'h5, "R11 peripheral ignores busy write", v, 5);
    chk(words == 4, "R11 restart ignored, word count", words, 4);
    reg_wr(3'd4, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule